// File: doc/BRIEF.md
# Fan Spin-Up Sequencer

This block governs how a fan is brought from rest to its normal drive level. While the fan-enable request is held high, the block first drives the duty output at its maximum code. It keeps that level until the fan shows it is turning, which means two tachometer edges have been seen. It then passes the programmed running duty straight through. A programmable startup window, measured in millisecond ticks, watches the spin-up phase. If the window closes before the second tach edge, the block raises a sticky interrupt and still hands over to the running duty, so the fan is never left undriven.

Setting the fixed-time mode input changes the spin-up rule. The tach input is then ignored, and maximum duty is held for exactly the length of the selected window. The duty value passes between the block and a PWM generator as a plain level. There is no valid/ready handshake and no back-pressure: the output is valid on every cycle, and the running duty input is sampled on every cycle. The block does not generate the PWM waveform itself.

Top module: `fan_spinup_seq`

## Requirements
- R1: After reset the duty output is 0, the interrupt is low and the block is idle.
- R2: While start_req is low the block is idle with duty 0. Dropping start_req in any state returns it to idle on the next clock.
- R3: A start_req seen while idle starts spin-up on the next clock. During spin-up the duty output is all ones (255 by default). Tach and tick inputs in the entry cycle are not counted.
- R4: In tach mode (fixed_mode=0), the clock that sees the second tach pulse of a spin-up ends it. From the next cycle the duty output follows run_duty.
- R5: The window code maps to millisecond ticks as follows: 0 none, 1→100, 2→250, 3→400, 4→667, 5→1000, 6→2000, 7→4000. The window closes on the clock that sees its Nth tick.
- R6: In tach mode with a nonzero code, if the window closes before two pulses, irq is set. The duty output follows run_duty from the next cycle on and stays there while start_req is held.
- R7: In tach mode with code 0, spin-up waits indefinitely for two pulses and never raises irq.
- R8: In fixed mode, tach pulses are ignored and full duty lasts exactly the window. Code 0 leaves spin-up after a single cycle. Fixed mode never raises irq.
- R9: irq stays set until a cycle with irq_clr high. If a set and a clear fall in the same cycle, the set wins.
- R10: If the second tach pulse arrives on the same clock that closes the window, spin-up ends normally and irq is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tach_pulse | input | 1 | One-cycle pulse per tach rising edge |
| start_req | input | 1 | Fan enable level; rising from idle starts spin-up |
| run_duty | input | DUTY_W | Running duty passed through after spin-up |
| tmo_code | input | 3 | Startup window code |
| fixed_mode | input | 1 | 1 = fixed-time spin-up, tach ignored |
| irq_clr | input | 1 | Clears the sticky interrupt |
| duty_out | output | DUTY_W | Effective duty |
| irq | output | 1 | Sticky spin-up failure interrupt |

## Verification
The assertions assume three things about the inputs. First, tmo_code and fixed_mode stay unchanged while a spin-up is in progress. Second, ms_tick and tach_pulse are single-cycle strobes. Third, irq_clr is a pulse, not a level held across a failure. The stimulus changes the code and the mode only while start_req is low. It issues every tick and tach edge as a one-cycle pulse driven on the falling clock edge, and raises irq_clr for one cycle at a time. One directed case aligns the closing tick with a tach edge, and another aligns it with a clear.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SPIN, ST_RUN, ST_FAIL} fss_state_e;

  localparam int TMR_W = 12;

  // Startup window length in millisecond ticks; zero means no window.
  function automatic logic [TMR_W-1:0] window_ms(input logic [2:0] code);
    logic [TMR_W-1:0] v;
    case (code)
      3'd1:    v = TMR_W'(100);
      3'd2:    v = TMR_W'(250);
      3'd3:    v = TMR_W'(400);
      3'd4:    v = TMR_W'(667);
      3'd5:    v = TMR_W'(1000);
      3'd6:    v = TMR_W'(2000);
      3'd7:    v = TMR_W'(4000);
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fss_ms_timer.sv
module fss_ms_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) elapsed <= '0;
    else if (tick && elapsed != '1) elapsed <= elapsed + 1'b1;
  end

  // The limit-th tick closes the window; limit 0 never closes it.
  assign expire = tick && (limit != '0) && (elapsed == limit - 1'b1);
endmodule

// File: rtl/fss_pulse_cnt.sv
module fss_pulse_cnt #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pulse,
  output logic reached
);
  localparam int CW = $clog2(NEED + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) seen <= '0;
    else if (pulse && seen != CW'(NEED)) seen <= seen + 1'b1;
  end

  // High on the clock whose pulse completes the required count.
  assign reached = pulse && (seen == CW'(NEED - 1));
endmodule

// File: rtl/fan_spinup_seq.sv
module fan_spinup_seq
  import fss_pkg::*;
#(
  parameter int DUTY_W     = 8,
  parameter int PULSE_NEED = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              tach_pulse,
  input  logic              start_req,
  input  logic [DUTY_W-1:0] run_duty,
  input  logic [2:0]        tmo_code,
  input  logic              fixed_mode,
  input  logic              irq_clr,
  output logic [DUTY_W-1:0] duty_out,
  output logic              irq
);
  fss_state_e       state, state_nx;
  logic             in_spin, cnt_clr, win_close, turned, irq_set;
  logic [TMR_W-1:0] limit;

  assign in_spin = (state == ST_SPIN);
  assign cnt_clr = (state == ST_IDLE);
  assign limit   = window_ms(tmo_code);

  fss_ms_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(ms_tick),
    .limit(limit), .expire(win_close)
  );

  fss_pulse_cnt #(.NEED(PULSE_NEED)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .pulse(tach_pulse),
    .reached(turned)
  );

  always_comb begin
    state_nx = state;
    irq_set  = 1'b0;
    case (state)
      ST_IDLE: if (start_req) state_nx = ST_SPIN;
      ST_SPIN: begin
        if (!start_req) state_nx = ST_IDLE;
        else if (fixed_mode) begin
          if (tmo_code == 3'd0 || win_close) state_nx = ST_RUN;
        end else if (turned) state_nx = ST_RUN;
        else if (win_close) begin
          state_nx = ST_FAIL;
          irq_set  = 1'b1;
        end
      end
      ST_RUN:  if (!start_req) state_nx = ST_IDLE;
      default: state_nx = start_req ? ST_RUN : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= state_nx;
      if (irq_set) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_comb begin
    if (state == ST_IDLE) duty_out = '0;
    else if (in_spin)     duty_out = '1;
    else                  duty_out = run_duty;
  end
endmodule

// File: rtl/fss_chk.sv
module fss_chk
  import fss_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic              tach_pulse,
  input logic              start_req,
  input logic [2:0]        tmo_code,
  input logic              fixed_mode,
  input logic              irq_clr,
  input logic [DUTY_W-1:0] duty_out,
  input logic              irq,
  input fss_state_e        state,
  input logic              turned
);
  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> (duty_out == '0));

  // R3
  spin_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPIN) && start_req && !tach_pulse && !ms_tick && !fixed_mode
      |=> (duty_out == '1));

  // R4
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPIN) && start_req && !fixed_mode && turned |=> (state == ST_RUN));

  // R7
  no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPIN) && !fixed_mode && (tmo_code == 3'd0) |=> !$rose(irq));

  // R8
  fixed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPIN) && fixed_mode |=> !$rose(irq));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

bind fan_spinup_seq fss_chk #(.DUTY_W(DUTY_W)) u_fss_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tach_pulse(tach_pulse),
  .start_req(start_req), .tmo_code(tmo_code), .fixed_mode(fixed_mode),
  .irq_clr(irq_clr), .duty_out(duty_out), .irq(irq), .state(state),
  .turned(turned)
);

// File: tb/tb_fan_spinup_seq.sv
module tb_fan_spinup_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0, tach_pulse = 1'b0, start_req = 1'b0;
  logic [7:0] run_duty = 8'd84;
  logic [2:0] tmo_code = 3'd2;
  logic       fixed_mode = 1'b0, irq_clr = 1'b0;
  logic [7:0] duty_out;
  logic       irq;

  int checks = 0, fails = 0;
  bit tick_auto = 1'b0, finished = 1'b0;
  int tick_div = 0;

  always #4 clk = ~clk;

  fan_spinup_seq dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tach_pulse(tach_pulse),
    .start_req(start_req), .run_duty(run_duty), .tmo_code(tmo_code),
    .fixed_mode(fixed_mode), .irq_clr(irq_clr), .duty_out(duty_out), .irq(irq)
  );

  function automatic int win(input int code);
    int t[8] = '{0, 100, 250, 400, 667, 1000, 2000, 4000};
    return t[code];
  endfunction

  // Reference model: 0 idle, 1 spin, 2 run, 3 failed
  int m_st = 0, m_tk = 0, m_pl = 0;
  bit m_irq = 0;
  always @(posedge clk) begin
    bit set_now, hit;
    set_now = 0;
    if (!rst_n) begin
      m_st = 0; m_irq = 0; m_tk = 0; m_pl = 0;
    end else begin
      case (m_st)
        0: if (start_req) begin m_st = 1; m_tk = 0; m_pl = 0; end
        1: if (!start_req) m_st = 0;
           else begin
             hit = ms_tick && win(tmo_code) != 0 && (m_tk + 1 == win(tmo_code));
             if (ms_tick) m_tk++;
             if (tach_pulse) m_pl++;
             if (fixed_mode) begin
               if (tmo_code == 0 || hit) m_st = 2;
             end else if (tach_pulse && m_pl == 2) m_st = 2;
             else if (hit) begin m_st = 3; set_now = 1; end
           end
        2: if (!start_req) m_st = 0;
        default: m_st = start_req ? 2 : 0;
      endcase
      if (set_now) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      int exp;
      exp = (m_st == 0) ? 0 : (m_st == 1) ? 255 : int'(run_duty);
      chk(duty_out == exp[7:0],
          (m_st == 0) ? "R2" : (m_st == 1) ? "R3" : "R4", duty_out, exp);
      chk(irq == m_irq, "R9", irq, m_irq);
    end
  end

  always @(negedge clk) begin
    if (tick_auto) begin
      tick_div = (tick_div + 1) % 4;
      ms_tick <= (tick_div == 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tach_once();
    @(negedge clk) tach_pulse <= 1'b1;
    @(negedge clk) tach_pulse <= 1'b0;
  endtask

  task automatic stop_fan();
    @(negedge clk) start_req <= 1'b0;
    cyc(2);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(duty_out == 0, "R1", duty_out, 0);
    chk(irq == 0, "R1", irq, 0);
    @(negedge clk) rst_n <= 1'b1;
    cyc(3);
    chk(duty_out == 0, "R1", duty_out, 0);

    // R4: two pulses end spin-up
    tick_auto = 1;
    @(negedge clk) start_req <= 1'b1;
    cyc(2);
    chk(duty_out == 255, "R3", duty_out, 255);
    cyc(30); tach_once(); cyc(20);
    chk(duty_out == 255, "R4", duty_out, 255);
    tach_once(); cyc(1);
    chk(duty_out == 84, "R4", duty_out, 84);
    @(negedge clk) run_duty <= 8'd170;
    cyc(1);
    chk(duty_out == 170, "R4", duty_out, 170);
    stop_fan();
    chk(duty_out == 0, "R2", duty_out, 0);

    // R2: drop during spin-up
    @(negedge clk) start_req <= 1'b1;
    cyc(10); stop_fan();
    chk(duty_out == 0, "R2", duty_out, 0);

    // R6: timeout with a single pulse
    tmo_code = 3'd1;
    @(negedge clk) start_req <= 1'b1;
    cyc(50); tach_once();
    cyc(420);
    chk(irq == 1, "R6", irq, 1);
    chk(duty_out == 170, "R6", duty_out, 170);
    stop_fan();
    chk(irq == 1, "R9", irq, 1);
    @(negedge clk) irq_clr <= 1'b1;
    @(negedge clk) irq_clr <= 1'b0;
    chk(irq == 0, "R9", irq, 0);

    // R7: code 0 waits indefinitely
    tmo_code = 3'd0;
    @(negedge clk) start_req <= 1'b1;
    cyc(17000);
    chk(duty_out == 255, "R7", duty_out, 255);
    chk(irq == 0, "R7", irq, 0);
    tach_once(); tach_once(); cyc(1);
    chk(duty_out == 170, "R7", duty_out, 170);
    stop_fan();

    // R8 / R5: fixed mode durations, pulses ignored
    fixed_mode = 1;
    for (int c = 1; c < 8; c++) begin
      int n;
      n = 0;
      tmo_code = 3'(c);
      @(negedge clk) start_req <= 1'b1;
      @(posedge clk); #2;
      tach_pulse = 1'b1;
      while (duty_out == 255 && n < 5000) begin
        @(posedge clk); #2;
        if (ms_tick) n++;
        tach_pulse = ~tach_pulse;
      end
      tach_pulse = 1'b0;
      chk(n == win(c), "R5", n, win(c));
      chk(irq == 0, "R8", irq, 0);
      stop_fan();
    end
    tmo_code = 3'd0;
    @(negedge clk) start_req <= 1'b1;
    cyc(1);
    chk(duty_out == 255, "R8", duty_out, 255);
    cyc(1);
    chk(duty_out == 170, "R8", duty_out, 170);
    stop_fan();
    fixed_mode = 0;

    // R10: second pulse on the closing tick
    tick_auto = 0;
    @(negedge clk) ms_tick <= 1'b0;
    tmo_code = 3'd1;
    @(negedge clk) start_req <= 1'b1;
    cyc(1); tach_once();
    for (int i = 0; i < 99; i++) begin
      @(negedge clk) ms_tick <= 1'b1;
      @(negedge clk) ms_tick <= 1'b0;
    end
    @(negedge clk) begin ms_tick <= 1'b1; tach_pulse <= 1'b1; end
    @(negedge clk) begin ms_tick <= 1'b0; tach_pulse <= 1'b0; end
    chk(irq == 0, "R10", irq, 0);
    chk(duty_out == 170, "R10", duty_out, 170);
    stop_fan();

    // R9: set wins over a simultaneous clear
    @(negedge clk) start_req <= 1'b1;
    cyc(1);
    for (int i = 0; i < 99; i++) begin
      @(negedge clk) ms_tick <= 1'b1;
      @(negedge clk) ms_tick <= 1'b0;
    end
    @(negedge clk) begin ms_tick <= 1'b1; irq_clr <= 1'b1; end
    @(negedge clk) begin ms_tick <= 1'b0; irq_clr <= 1'b0; end
    chk(irq == 1, "R9", irq, 1);
    chk(duty_out == 170, "R6", duty_out, 170);
    stop_fan();

    cyc(4);
    finish_run();
  end
endmodule